// File: doc/BRIEF.md
# Interrupt Trigger Notification Generator

This block is the interrupt front end of a host bridge. Interrupt events arrive one at a time on an event port. Each event carries a source index, a level and a flag that says the caller has already checked the source's PQ state. The block keeps a 64-bit level word with one bit per source. For every accepted assertion it marks the source as pending. It then turns each pending source into a single 64-bit trigger write towards a programmable notification address. If several sources are pending, the lowest index goes first.

Software reaches five 64-bit registers through a simple register port. The registers are a control word (store-based end-of-interrupt mode and a sticky write-error bit), an interrupt control word (method select and source reset), the event-page base (page size and mapping), the notification target and the source number base. The trigger payload is the base ORed with the source index, plus the checked flag. A trigger is silently dropped while the notification target is not marked valid. While the level-signalled method is selected, no event has any effect.

Top module: `irq_trig_gen`

## Requirements
- R1: After reset the level word (byte offset 0x78) reads zero, every stored register reads zero, no request is outstanding, and the store-EOI and page outputs are low.
- R2: An event with an index below NSRC and state 1 sets bit (63 - index) of the level word; the same event with state 0 clears that bit. The change is readable one clock after the event.
- R3: An accepted assertion, with bit 0 of the notification register (0x68) set, raises `ntf_valid` two clocks after the event. `ntf_addr` is then that register with bit 0 cleared. `ntf_data` has bits 63:32 zero, and bits 31:0 equal to (upper 32 bits of the base register 0x70) OR index, with bit 31 also set when `evt_pq` was 1.
- R4: While `ntf_valid` is high and `ntf_ready` is low, `ntf_valid`, `ntf_addr` and `ntf_data` hold their values.
- R5: A pending source that is picked while bit 0 of 0x68 is clear is dropped without a request, and setting that bit afterwards does not bring the request back.
- R6: An event whose index is NSRC or higher changes neither the level word nor the request port.
- R7: While bit 63 of the interrupt control register (0x58) is set, events change neither the level word nor the request port.
- R8: A write to 0x58 with bit 62 set clears the whole level word and every pending source. The written value is stored and read back.
- R9: In the page base register (0x60), `pg_64k` follows bit 62, and `pg_addr` is the register with bits 62 and 0 cleared. `pg_map` pulses for one clock after a write that takes bit 0 from 0 to 1, and `pg_unmap` pulses for one clock after a write that takes it from 1 to 0.
- R10: `store_eoi` follows bit 51 of the control register (0x20).
- R11: Reads of any offset other than 0x20, 0x58, 0x60, 0x68, 0x70 and 0x78 return all ones. Writes to 0x78 or to unlisted offsets change nothing.
- R12: A request accepted with `ntf_err` high sets bit 0 of the control register, and the bit stays set. A write to 0x20 with bit 0 set clears it.
- R13: When several sources are pending, they are sent one request at a time, lowest index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` (combinational) |
| evt_valid | input | 1 | Interrupt event strobe |
| evt_idx | input | IDXW | Source index of the event |
| evt_state | input | 1 | 1 = assertion, 0 = deassertion |
| evt_pq | input | 1 | PQ state already checked by the caller |
| ntf_valid | output | 1 | Trigger write request |
| ntf_ready | input | 1 | Request accepted |
| ntf_err | input | 1 | Error response, qualified by acceptance |
| ntf_addr | output | 64 | Trigger write address |
| ntf_data | output | 64 | Trigger write data |
| store_eoi | output | 1 | Store-based end-of-interrupt enabled |
| pg_64k | output | 1 | Event page size is 64 KiB (else 4 KiB) |
| pg_addr | output | 64 | Event page region base address |
| pg_map | output | 1 | One-clock pulse: map the event page region |
| pg_unmap | output | 1 | One-clock pulse: unmap the event page region |

## Verification
Each result has its own due time. Register writes and level updates are visible at the falling edge that follows the capturing rising edge. Page pulses show up at that same falling edge and are gone one clock later. A trigger request appears one clock after the level update, because picking a source and launching the request take separate edges. After an acceptance, the next request appears after one idle clock.

The bench drives every input at a falling edge and samples at the next falling edge, waiting exactly those counts. Where an event must have no effect (dropped, rejected, method set, source reset), the bench watches the request port for several extra clocks, so that a late request would also be seen.

// File: rtl/itg_pkg.sv
package itg_pkg;
  // register byte offsets (8-byte registers)
  localparam logic [7:0] A_CTRL  = 8'h20;
  localparam logic [7:0] A_ICTL  = 8'h58;
  localparam logic [7:0] A_PAGE  = 8'h60;
  localparam logic [7:0] A_NTF   = 8'h68;
  localparam logic [7:0] A_OFS   = 8'h70;
  localparam logic [7:0] A_LEVEL = 8'h78;

  // bit positions, LSB-numbered
  localparam int B_METHOD = 63;  // interrupt control: level method
  localparam int B_SRCRST = 62;  // interrupt control: reset sources
  localparam int B_PG64K  = 62;  // page base: 64 KiB pages
  localparam int B_VALID  = 0;   // page base / notification valid
  localparam int B_SEOI   = 51;  // control: store EOI
  localparam int B_ERR    = 0;   // control: sticky write error

  // level word bit that belongs to a source (source 0 in the MSB)
  function automatic logic [63:0] src_bit(input int unsigned n);
    return 64'h1 << (63 - n);
  endfunction

  // trigger payload: base | index | checked flag in bit 31
  function automatic logic [63:0] trig_word(input logic [31:0] base,
                                            input logic [31:0] idx,
                                            input logic        pq);
    return {32'h0, base | idx | {pq, 31'h0}};
  endfunction
endpackage

// File: rtl/itg_regs.sv
module itg_regs
  import itg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [7:0]  addr,
  input  logic [63:0] wdata,
  input  logic        err_set,
  output logic [63:0] ctrl_q,
  output logic [63:0] ictl_q,
  output logic [63:0] page_q,
  output logic [63:0] ntf_q,
  output logic [63:0] ofs_q,
  output logic        err_q,
  output logic        clr_all,
  output logic        map_q,
  output logic        unmap_q
);
  logic wr_ctrl, wr_ictl, wr_page, wr_ntf, wr_ofs;

  assign wr_ctrl = we && (addr == A_CTRL);
  assign wr_ictl = we && (addr == A_ICTL);
  assign wr_page = we && (addr == A_PAGE);
  assign wr_ntf  = we && (addr == A_NTF);
  assign wr_ofs  = we && (addr == A_OFS);
  assign clr_all = wr_ictl && wdata[B_SRCRST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ictl_q  <= '0;
      page_q  <= '0;
      ntf_q   <= '0;
      ofs_q   <= '0;
      err_q   <= 1'b0;
      map_q   <= 1'b0;
      unmap_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= {wdata[63:1], 1'b0};
      if (wr_ictl) ictl_q <= wdata;
      if (wr_page) page_q <= wdata;
      if (wr_ntf)  ntf_q  <= wdata;
      if (wr_ofs)  ofs_q  <= wdata;
      if (err_set)                        err_q <= 1'b1;
      else if (wr_ctrl && wdata[B_ERR])   err_q <= 1'b0;
      map_q   <= wr_page &&  wdata[B_VALID] && !page_q[B_VALID];
      unmap_q <= wr_page && !wdata[B_VALID] &&  page_q[B_VALID];
    end
  end
endmodule

// File: rtl/itg_srcs.sv
module itg_srcs #(
  parameter int NSRC = 14,
  parameter int IDXW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_valid,
  input  logic [IDXW-1:0] evt_idx,
  input  logic            evt_state,
  input  logic            evt_pq,
  input  logic            method,
  input  logic            clr_all,
  input  logic            take,
  output logic [63:0]     level,
  output logic            any_pend,
  output logic [IDXW-1:0] sel_idx,
  output logic            sel_pq
);
  localparam int LVLW = 64;

  logic [NSRC-1:0] lvl_q, pend_q, pq_q;
  logic            accept;

  assign accept = evt_valid && !method && (32'(evt_idx) < NSRC);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic hit;
    assign hit = accept && (evt_idx == IDXW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n || clr_all) begin
        lvl_q[g]  <= 1'b0;
        pend_q[g] <= 1'b0;
        pq_q[g]   <= 1'b0;
      end else begin
        if (hit) lvl_q[g] <= evt_state;
        if (hit && evt_state) begin
          pend_q[g] <= 1'b1;
          pq_q[g]   <= evt_pq;
        end else if (take && sel_idx == IDXW'(g)) begin
          pend_q[g] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    level = '0;
    for (int i = 0; i < NSRC; i++) level[LVLW-1-i] = lvl_q[i];
  end

  always_comb begin
    sel_idx = '0;
    sel_pq  = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        sel_idx = IDXW'(i);
        sel_pq  = pq_q[i];
      end
    end
  end

  assign any_pend = |pend_q;
endmodule

// File: rtl/itg_tx.sv
module itg_tx
  import itg_pkg::*;
#(
  parameter int IDXW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            any_pend,
  input  logic [IDXW-1:0] sel_idx,
  input  logic            sel_pq,
  input  logic [63:0]     ntf_cfg,
  input  logic [31:0]     base,
  input  logic            ready,
  input  logic            err,
  output logic            take,
  output logic            err_set,
  output logic            valid_q,
  output logic [63:0]     addr_q,
  output logic [63:0]     data_q
);
  assign take    = any_pend && !valid_q;
  assign err_set = valid_q && ready && err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (take && ntf_cfg[B_VALID]) begin
      valid_q <= 1'b1;
      addr_q  <= {ntf_cfg[63:1], 1'b0};
      data_q  <= trig_word(base, 32'(sel_idx), sel_pq);
    end else if (valid_q && ready) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_trig_gen.sv
module irq_trig_gen
  import itg_pkg::*;
#(
  parameter int NSRC = 14,
  parameter int IDXW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [7:0]      reg_addr,
  input  logic [63:0]     reg_wdata,
  output logic [63:0]     reg_rdata,
  input  logic            evt_valid,
  input  logic [IDXW-1:0] evt_idx,
  input  logic            evt_state,
  input  logic            evt_pq,
  output logic            ntf_valid,
  input  logic            ntf_ready,
  input  logic            ntf_err,
  output logic [63:0]     ntf_addr,
  output logic [63:0]     ntf_data,
  output logic            store_eoi,
  output logic            pg_64k,
  output logic [63:0]     pg_addr,
  output logic            pg_map,
  output logic            pg_unmap
);
  logic [63:0]     ctrl_q, ictl_q, page_q, ntf_q, ofs_q, level_w;
  logic            err_q, clr_all, take, err_set, any_pend, sel_pq;
  logic [IDXW-1:0] sel_idx;

  itg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .err_set(err_set), .ctrl_q(ctrl_q), .ictl_q(ictl_q), .page_q(page_q),
    .ntf_q(ntf_q), .ofs_q(ofs_q), .err_q(err_q), .clr_all(clr_all),
    .map_q(pg_map), .unmap_q(pg_unmap)
  );

  itg_srcs #(.NSRC(NSRC), .IDXW(IDXW)) u_srcs (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_idx(evt_idx),
    .evt_state(evt_state), .evt_pq(evt_pq), .method(ictl_q[B_METHOD]),
    .clr_all(clr_all), .take(take), .level(level_w), .any_pend(any_pend),
    .sel_idx(sel_idx), .sel_pq(sel_pq)
  );

  itg_tx #(.IDXW(IDXW)) u_tx (
    .clk(clk), .rst_n(rst_n), .any_pend(any_pend), .sel_idx(sel_idx),
    .sel_pq(sel_pq), .ntf_cfg(ntf_q), .base(ofs_q[63:32]), .ready(ntf_ready),
    .err(ntf_err), .take(take), .err_set(err_set), .valid_q(ntf_valid),
    .addr_q(ntf_addr), .data_q(ntf_data)
  );

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {ctrl_q[63:1], err_q};
      A_ICTL:  reg_rdata = ictl_q;
      A_PAGE:  reg_rdata = page_q;
      A_NTF:   reg_rdata = ntf_q;
      A_OFS:   reg_rdata = ofs_q;
      A_LEVEL: reg_rdata = level_w;
      default: reg_rdata = '1;
    endcase
  end

  assign store_eoi = ctrl_q[B_SEOI];
  assign pg_64k    = page_q[B_PG64K];
  assign pg_addr   = page_q & ~(64'h1 << B_PG64K) & ~64'h1;
endmodule

// File: rtl/itg_chk.sv
module itg_chk #(
  parameter int NSRC = 14,
  parameter int IDXW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic            evt_valid,
  input logic [IDXW-1:0] evt_idx,
  input logic            ntf_valid,
  input logic            ntf_ready,
  input logic            ntf_err,
  input logic [63:0]     ntf_addr,
  input logic [63:0]     ntf_data,
  input logic            pg_map,
  input logic            pg_unmap,
  input logic [63:0]     level_w,
  input logic            method_w,
  input logic            ntf_ok_w,
  input logic            page_ok_w,
  input logic            err_w
);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && !ntf_ready) |=> (ntf_valid && $stable(ntf_addr) && $stable(ntf_data)));

  assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ntf_valid) |-> $past(ntf_ok_w));

  assert_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && 32'(evt_idx) >= NSRC && !reg_we) |=> $stable(level_w));

  assert_method_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && method_w && !reg_we) |=> $stable(level_w));

  assert_map_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pg_map |-> (page_ok_w && !pg_unmap));

  assert_unmap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pg_unmap |-> !page_ok_w);

  assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_w) |-> $past(ntf_valid && ntf_ready && ntf_err));
endmodule

bind irq_trig_gen itg_chk #(.NSRC(NSRC), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .evt_valid(evt_valid),
  .evt_idx(evt_idx), .ntf_valid(ntf_valid), .ntf_ready(ntf_ready),
  .ntf_err(ntf_err), .ntf_addr(ntf_addr), .ntf_data(ntf_data),
  .pg_map(pg_map), .pg_unmap(pg_unmap), .level_w(level_w),
  .method_w(ictl_q[63]), .ntf_ok_w(ntf_q[0]), .page_ok_w(page_q[0]),
  .err_w(err_q)
);

// File: tb/test_irq_trig_gen.sv
`timescale 1ns/1ps
module test_irq_trig_gen;
  localparam int NSRC = 14;
  localparam int IDXW = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_we = 1'b0;
  logic [7:0]      reg_addr = 8'h00;
  logic [63:0]     reg_wdata = '0;
  logic [63:0]     reg_rdata;
  logic            evt_valid = 1'b0;
  logic [IDXW-1:0] evt_idx = '0;
  logic            evt_state = 1'b0;
  logic            evt_pq = 1'b0;
  logic            ntf_valid;
  logic            ntf_ready = 1'b0;
  logic            ntf_err = 1'b0;
  logic [63:0]     ntf_addr, ntf_data;
  logic            store_eoi, pg_64k, pg_map, pg_unmap;
  logic [63:0]     pg_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] lvl_exp = '0;

  always #4 clk = ~clk;

  irq_trig_gen #(.NSRC(NSRC), .IDXW(IDXW)) i_irq_trig_gen (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic evt(input int idx, input logic st, input logic pq);
    @(negedge clk);
    evt_valid = 1'b1; evt_idx = IDXW'(idx); evt_state = st; evt_pq = pq;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic accept(input logic err);
    @(negedge clk);
    ntf_ready = 1'b1; ntf_err = err;
    @(negedge clk);
    ntf_ready = 1'b0; ntf_err = 1'b0;
  endtask

  task automatic quiet(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, {63'h0, ntf_valid}, 64'h0);
    end
  endtask

  function automatic logic [63:0] sbit(input int n);
    return 64'h1 << (63 - n);
  endfunction

  task automatic t_reset_state();
    logic [63:0] v;
    rd(8'h78, v); check("R1 level", v, 64'h0);
    rd(8'h20, v); check("R1 ctrl", v, 64'h0);
    rd(8'h68, v); check("R1 ntf", v, 64'h0);
    check("R1 req", {63'h0, ntf_valid}, 64'h0);
    check("R1 outs", {60'h0, store_eoi, pg_64k, pg_map, pg_unmap}, 64'h0);
  endtask

  task automatic t_regs();
    logic [63:0] v;
    wr(8'h20, 64'h1 << 51);
    check("R10 store_eoi on", {63'h0, store_eoi}, 64'h1);
    rd(8'h20, v); check("R10 readback", v, 64'h1 << 51);
    wr(8'h20, 64'h0);
    check("R10 store_eoi off", {63'h0, store_eoi}, 64'h0);
    rd(8'h40, v); check("R11 unlisted read", v, '1);
    rd(8'h21, v); check("R11 misaligned read", v, '1);
    wr(8'h78, '1);
    rd(8'h78, v); check("R11 level write ignored", v, 64'h0);
    wr(8'h50, 64'h1234);
    rd(8'h70, v); check("R11 unlisted write ignored", v, 64'h0);
  endtask

  task automatic t_page();
    wr(8'h60, 64'h0000_1234_5670_0000 | (64'h1 << 62) | 64'h1);
    check("R9 map pulse", {62'h0, pg_map, pg_unmap}, 64'h2);
    check("R9 64k", {63'h0, pg_64k}, 64'h1);
    check("R9 addr", pg_addr, 64'h0000_1234_5670_0000);
    @(negedge clk);
    check("R9 map one clock", {62'h0, pg_map, pg_unmap}, 64'h0);
    wr(8'h60, 64'h0000_1234_5670_0001);
    check("R9 no pulse on valid rewrite", {62'h0, pg_map, pg_unmap}, 64'h0);
    check("R9 4k", {63'h0, pg_64k}, 64'h0);
    wr(8'h60, 64'h0);
    check("R9 unmap pulse", {62'h0, pg_map, pg_unmap}, 64'h1);
    @(negedge clk);
    check("R9 unmap one clock", {62'h0, pg_map, pg_unmap}, 64'h0);
  endtask

  task automatic t_level_drop();
    logic [63:0] v;
    evt(3, 1'b1, 1'b0); lvl_exp |= sbit(3);
    rd(8'h78, v); check("R2 set src3", v, lvl_exp);
    evt(13, 1'b1, 1'b0); lvl_exp |= sbit(13);
    rd(8'h78, v); check("R2 set src13", v, lvl_exp);
    evt(3, 1'b0, 1'b0); lvl_exp &= ~sbit(3);
    rd(8'h78, v); check("R2 clear src3", v, lvl_exp);
    evt(NSRC, 1'b1, 1'b0);
    rd(8'h78, v); check("R6 index NSRC rejected", v, lvl_exp);
    evt(20, 1'b1, 1'b0);
    rd(8'h78, v); check("R6 index 20 rejected", v, lvl_exp);
    quiet("R5 no request while invalid", 2);
    wr(8'h68, 64'h0000_00AB_CDEF_0001);
    quiet("R5 dropped stays dropped", 3);
  endtask

  task automatic t_trigger();
    wr(8'h70, 64'h0000_1000_0000_0000);
    evt(5, 1'b1, 1'b1); lvl_exp |= sbit(5);
    @(negedge clk);
    check("R3 valid", {63'h0, ntf_valid}, 64'h1);
    check("R3 addr", ntf_addr, 64'h0000_00AB_CDEF_0000);
    check("R3 data", ntf_data, 64'h0000_0000_8000_1005);
    @(negedge clk); @(negedge clk);
    check("R4 valid held", {63'h0, ntf_valid}, 64'h1);
    check("R4 addr held", ntf_addr, 64'h0000_00AB_CDEF_0000);
    check("R4 data held", ntf_data, 64'h0000_0000_8000_1005);
    accept(1'b1);
    check("R4 released", {63'h0, ntf_valid}, 64'h0);
  endtask

  task automatic t_error();
    logic [63:0] v;
    rd(8'h20, v); check("R12 sticky set", v, 64'h1);
    @(negedge clk);
    rd(8'h20, v); check("R12 stays set", v, 64'h1);
    wr(8'h20, 64'h1);
    rd(8'h20, v); check("R12 cleared", v, 64'h0);
  endtask

  task automatic t_order();
    evt(0, 1'b1, 1'b0); lvl_exp |= sbit(0);
    @(negedge clk);
    check("R13 first idx0", ntf_data, 64'h0000_0000_0000_1000);
    evt(9, 1'b1, 1'b0); lvl_exp |= sbit(9);
    evt(2, 1'b1, 1'b0); lvl_exp |= sbit(2);
    accept(1'b0);
    @(negedge clk);
    check("R13 valid second", {63'h0, ntf_valid}, 64'h1);
    check("R13 second idx2", ntf_data, 64'h0000_0000_0000_1002);
    accept(1'b0);
    @(negedge clk);
    check("R13 third idx9", ntf_data, 64'h0000_0000_0000_1009);
    accept(1'b0);
    quiet("R13 queue empty", 2);
  endtask

  task automatic t_method();
    logic [63:0] v;
    wr(8'h58, 64'h1 << 63);
    evt(7, 1'b1, 1'b0);
    rd(8'h78, v); check("R7 level unchanged", v, lvl_exp);
    quiet("R7 no request", 3);
    evt(0, 1'b0, 1'b0);
    rd(8'h78, v); check("R7 deassert ignored", v, lvl_exp);
    wr(8'h58, 64'h0);
  endtask

  task automatic t_src_reset();
    logic [63:0] v;
    evt(1, 1'b1, 1'b0); lvl_exp |= sbit(1);
    @(negedge clk);
    check("R8 busy idx1", ntf_data, 64'h0000_0000_0000_1001);
    evt(6, 1'b1, 1'b0);
    wr(8'h58, 64'h1 << 62); lvl_exp = '0;
    rd(8'h78, v); check("R8 level cleared", v, 64'h0);
    rd(8'h58, v); check("R8 value stored", v, 64'h1 << 62);
    accept(1'b0);
    quiet("R8 pending cleared", 3);
    wr(8'h58, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_regs();
    t_page();
    t_level_drop();
    t_trigger();
    t_error();
    t_order();
    t_method();
    t_src_reset();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule